// File: doc/BRIEF.md
# Serial Engine Command Processor

This block interprets a stream of command bytes from a host. It drives two banks of general-purpose pins and a one-wire serial output with its own clock. Each command is one opcode byte, followed by zero to two argument bytes and, for block writes, a run of payload bytes. The commands do the following:
- Load a pin bank with an output value and a direction mask.
- Set a 16-bit clock divisor.
- Switch a divide-by-5 prescaler on or off.
- Shift a counted run of bytes out on the serial line.
- Sample the high pin bank and return the levels.

Any response goes out as single-cycle pulses on a byte output stream.

The serial clock is derived from the block clock. One half period of the serial clock lasts (divisor + 1) block-clock cycles, multiplied by 5 while the prescaler is enabled. Payload bytes leave least significant bit first. Each data bit is stable on the serial line at the rising serial-clock edge. While a byte is being shifted, the command input is closed. It opens again only to take the next payload byte of the same block.

Top module: `sercmd_engine`

## Requirements
- R1: After reset, both pin banks have value and direction 0, `sclk` is low, `rsp_valid` is low, `cmd_ready` is high, the divisor is 0 and the prescaler is enabled.
- R2: Opcode 0x10 takes a value byte and then a mask byte for the low bank. From the cycle after the mask byte is accepted, `lo_oe` equals the mask and `lo_pin` equals value AND mask, so a pin whose direction bit is 0 outputs 0 whatever its value bit. The low bank does not change at any other time.
- R3: Opcode 0x11 does the same for the high bank (`hi_pin`, `hi_oe`) and leaves the low bank unchanged.
- R4: Opcode 0x12 produces exactly one response byte, equal to `hi_in` as sampled in the cycle the opcode is accepted, with `rsp_valid` high in the following cycle.
- R5: Opcode 0x20 takes two divisor bytes, low byte first. During a block write, the serial clock period is 2 × (divisor + 1) × P block-clock cycles, where P = 5 with the prescaler enabled and P = 1 with it disabled.
- R6: Opcode 0x21 is a single-byte command that disables the prescaler. Opcode 0x22 is a single-byte command that enables it.
- R7: Opcode 0x30 takes a 16-bit length, low byte first, encoding count − 1. Exactly count payload bytes follow. Each payload byte is shifted out bit 0 first, with 8 rising edges of `sclk`, and `sdo` stays unchanged across each rising edge. `sclk` is low whenever no byte is being shifted.
- R8: Any other opcode produces the response byte 0xFA, then a response byte equal to the opcode, on consecutive cycles. Decoding then resumes with the next byte.
- R9: While a byte is being shifted, `cmd_ready` is low. A byte held on the input during that time has no effect on the pins or on the shifted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the base of the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command, argument or payload byte |
| cmd_ready | output | 1 | Byte is taken on a clock edge where valid and ready are both high |
| rsp_valid | output | 1 | Response byte pulse |
| rsp_data | output | 8 | Response byte |
| lo_pin | output | 8 | Low bank output levels |
| lo_oe | output | 8 | Low bank drive enables (1 = output) |
| hi_pin | output | 8 | High bank output levels |
| hi_oe | output | 8 | High bank drive enables (1 = output) |
| hi_in | input | 8 | High bank input levels |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, valid on the rising `sclk` edge |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor and a prescaler ratio of 5. It programs small divisors, so that half periods of 3, 5 and 10 cycles all fit in short runs. With these settings, the period check covers the prescaler in both states and a divisor other than zero. The multi-byte block write covers the gap between payload bytes. The bench also holds an opcode on the input while a byte is shifting, to show that the input is closed.

// File: rtl/sercmd_pkg.sv
// Package: shared opcodes, response codes and decoder state type for the
// serial engine command processor. Assumes byte-wide command stream.
package sercmd_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_SET_LO  = 8'h10;
    localparam logic [BYTE_W-1:0] OP_SET_HI  = 8'h11;
    localparam logic [BYTE_W-1:0] OP_GET_HI  = 8'h12;
    localparam logic [BYTE_W-1:0] OP_SET_DIV = 8'h20;
    localparam logic [BYTE_W-1:0] OP_PRE_OFF = 8'h21;
    localparam logic [BYTE_W-1:0] OP_PRE_ON  = 8'h22;
    localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h30;
    localparam logic [BYTE_W-1:0] RSP_ERROR  = 8'hFA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG1,
        ST_ARG2,
        ST_PAYLOAD,
        ST_SHIFT,
        ST_ERR2
    } dec_state_t;
endpackage

// File: rtl/sercmd_clkgen.sv
// Module: half-period tick generator for the serial clock.
// Holds the divisor and prescaler settings. While run is high it issues one
// tick every (divisor+1)*P cycles, P = PRE_RATIO when the prescaler is on.
// Assumes settings are only changed while run is low.
module sercmd_clkgen #(
    parameter int DIV_W     = 16,
    parameter int PRE_RATIO = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    input  logic             pre_set,
    input  logic             pre_clr,
    input  logic             run,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1 + $clog2(PRE_RATIO + 1);

    logic [DIV_W-1:0] div_q;
    logic             pre_en_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] limit;

    // Settings registers: divisor and prescaler enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            pre_en_q <= 1'b1;
        end else begin
            if (div_load) div_q <= div_value;
            if (pre_set)       pre_en_q <= 1'b1;
            else if (pre_clr)  pre_en_q <= 1'b0;
        end
    end

    // Terminal count of one half period.
    always_comb begin
        half_len = CNT_W'(div_q) + CNT_W'(1);
        ratio    = pre_en_q ? CNT_W'(PRE_RATIO) : CNT_W'(1);
        limit    = (half_len * ratio) - CNT_W'(1);
    end

    // Half-period counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q == limit) cnt_q <= '0;
        else cnt_q <= cnt_q + CNT_W'(1);
    end

    assign tick = run && (cnt_q == limit);

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/sercmd_shifter.sv
// Module: serial shifter. Loads one word, drives it LSB first on sdo, with
// sclk idle low, rising mid-bit and falling at the bit boundary, so data is
// stable at each rising edge. Advances one half period per tick.
module sercmd_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tick,
    output logic         busy,
    output logic         done,
    output logic         sclk,
    output logic         sdo
);
    localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic [BIT_W-1:0] bit_q;

    // Shift sequencing: load, rise, fall-and-advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            sclk  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                sh_q  <= load_data;
                bit_q <= '0;
                busy  <= 1'b1;
                sclk  <= 1'b0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BIT_W'(1);
                        sh_q  <= sh_q >> 1;
                    end
                end
            end
        end
    end

    assign sdo = sh_q[0];

    assert_sdo_stable_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdo));
    assert_sclk_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
endmodule

// File: rtl/sercmd_gpio.sv
// Module: two general-purpose pin banks. Each bank holds an output value and
// a direction mask; a pin drives its value only where its direction bit is 1.
module sercmd_gpio #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lo_wr,
    input  logic         hi_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] wr_dir,
    output logic [W-1:0] lo_pin,
    output logic [W-1:0] lo_oe,
    output logic [W-1:0] hi_pin,
    output logic [W-1:0] hi_oe
);
    localparam int NBANK = 2;

    logic [W-1:0] val_q [NBANK];
    logic [W-1:0] dir_q [NBANK];
    logic [NBANK-1:0] wr;

    assign wr = {hi_wr, lo_wr};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Bank register: value and direction updated together.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[b] <= '0;
                dir_q[b] <= '0;
            end else if (wr[b]) begin
                val_q[b] <= wr_val;
                dir_q[b] <= wr_dir;
            end
        end
    end

    assign lo_pin = val_q[0] & dir_q[0];
    assign lo_oe  = dir_q[0];
    assign hi_pin = val_q[1] & dir_q[1];
    assign hi_oe  = dir_q[1];

    assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> ($stable(lo_pin) && $stable(lo_oe)));
    assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> ($stable(hi_pin) && $stable(hi_oe)));
endmodule

// File: rtl/sercmd_decoder.sv
// Module: command decoder. Parses opcode, argument and payload bytes, issues
// one-cycle strobes to the pin banks, clock generator and shifter, and emits
// response bytes. Assumes the shifter reports completion with a done pulse.
module sercmd_decoder
    import sercmd_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              shift_done,
    input  logic [BYTE_W-1:0] hi_in,
    output logic              lo_wr,
    output logic              hi_wr,
    output logic [BYTE_W-1:0] wr_val,
    output logic [BYTE_W-1:0] wr_dir,
    output logic              div_load,
    output logic [DIV_W-1:0]  div_value,
    output logic              pre_set,
    output logic              pre_clr,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    dec_state_t        st;
    logic [BYTE_W-1:0] op_q;
    logic [BYTE_W-1:0] arg1_q;
    logic [LEN_W-1:0]  remain_q;
    logic              acc;

    assign in_ready = (st == ST_IDLE) || (st == ST_ARG1) ||
                      (st == ST_ARG2) || (st == ST_PAYLOAD);
    assign acc = in_valid && in_ready;

    // Strobes toward the datapath, decoded from the byte being accepted.
    always_comb begin
        lo_wr     = acc && (st == ST_ARG2) && (op_q == OP_SET_LO);
        hi_wr     = acc && (st == ST_ARG2) && (op_q == OP_SET_HI);
        div_load  = acc && (st == ST_ARG2) && (op_q == OP_SET_DIV);
        wr_val    = arg1_q;
        wr_dir    = in_data;
        div_value = DIV_W'({in_data, arg1_q});
        pre_set   = acc && (st == ST_IDLE) && (in_data == OP_PRE_ON);
        pre_clr   = acc && (st == ST_IDLE) && (in_data == OP_PRE_OFF);
        sh_load   = acc && (st == ST_PAYLOAD);
        sh_data   = in_data;
    end

    // Command sequencing and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            op_q      <= '0;
            arg1_q    <= '0;
            remain_q  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (st)
                ST_IDLE: if (acc) begin
                    op_q <= in_data;
                    case (in_data)
                        OP_SET_LO, OP_SET_HI, OP_SET_DIV, OP_WRITE: st <= ST_ARG1;
                        OP_GET_HI: begin
                            out_valid <= 1'b1;
                            out_data  <= hi_in;
                        end
                        OP_PRE_OFF, OP_PRE_ON: st <= ST_IDLE;
                        default: begin
                            out_valid <= 1'b1;
                            out_data  <= RSP_ERROR;
                            st        <= ST_ERR2;
                        end
                    endcase
                end
                ST_ERR2: begin
                    out_valid <= 1'b1;
                    out_data  <= op_q;
                    st        <= ST_IDLE;
                end
                ST_ARG1: if (acc) begin
                    arg1_q <= in_data;
                    st     <= ST_ARG2;
                end
                ST_ARG2: if (acc) begin
                    if (op_q == OP_WRITE) begin
                        remain_q <= {in_data, arg1_q};
                        st       <= ST_PAYLOAD;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_PAYLOAD: if (acc) st <= ST_SHIFT;
                ST_SHIFT: if (shift_done) begin
                    if (remain_q == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        remain_q <= remain_q - LEN_W'(1);
                        st       <= ST_PAYLOAD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_err_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR2) |=> (out_valid && (out_data == $past(op_q))));
    assert_read_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (st == ST_IDLE) && (in_data == OP_GET_HI)) |=> (out_valid && (out_data == $past(hi_in))));
endmodule

// File: rtl/sercmd_engine.sv
// Module: top of the serial engine command processor. Connects the decoder,
// pin banks, serial clock generator and shifter. Assumes a single clock that
// also serves as the serial clock base.
module sercmd_engine
    import sercmd_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PRE_RATIO = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_data,
    output logic       cmd_ready,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic [7:0] lo_pin,
    output logic [7:0] lo_oe,
    output logic [7:0] hi_pin,
    output logic [7:0] hi_oe,
    input  logic [7:0] hi_in,
    output logic       sclk,
    output logic       sdo
);
    logic              lo_wr, hi_wr, div_load, pre_set, pre_clr;
    logic              sh_load, sh_busy, sh_done, tick;
    logic [BYTE_W-1:0] wr_val, wr_dir, sh_data;
    logic [DIV_W-1:0]  div_value;

    sercmd_decoder #(.DIV_W(DIV_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cmd_valid), .in_data(cmd_data), .in_ready(cmd_ready),
        .shift_done(sh_done), .hi_in(hi_in),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_val(wr_val), .wr_dir(wr_dir),
        .div_load(div_load), .div_value(div_value),
        .pre_set(pre_set), .pre_clr(pre_clr),
        .sh_load(sh_load), .sh_data(sh_data),
        .out_valid(rsp_valid), .out_data(rsp_data)
    );

    sercmd_gpio #(.W(BYTE_W)) u_gpio (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_val(wr_val), .wr_dir(wr_dir),
        .lo_pin(lo_pin), .lo_oe(lo_oe), .hi_pin(hi_pin), .hi_oe(hi_oe)
    );

    sercmd_clkgen #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_clk (
        .clk(clk), .rst_n(rst_n),
        .div_load(div_load), .div_value(div_value),
        .pre_set(pre_set), .pre_clr(pre_clr),
        .run(sh_busy), .tick(tick)
    );

    sercmd_shifter #(.W(BYTE_W)) u_sh (
        .clk(clk), .rst_n(rst_n),
        .load(sh_load), .load_data(sh_data), .tick(tick),
        .busy(sh_busy), .done(sh_done), .sclk(sclk), .sdo(sdo)
    );

    assert_no_intake_while_shifting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !cmd_ready);
endmodule

// File: tb/sim_sercmd_engine.sv
// Scoreboard bench: drivers queue expected response and shifted bytes,
// monitors pop and compare as the design produces them.
module sim_sercmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ready, rsp_valid, sclk, sdo;
    logic [7:0] rsp_data, lo_pin, lo_oe, hi_pin, hi_oe;
    logic [7:0] hi_in = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] exp_rsp[$];
    logic [7:0] exp_sh[$];
    int exp_half = 5;

    always #4 clk = ~clk;

    sercmd_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lo_pin(lo_pin), .lo_oe(lo_oe), .hi_pin(hi_pin), .hi_oe(hi_oe),
        .hi_in(hi_in), .sclk(sclk), .sdo(sdo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        forever begin
            @(negedge clk);
            if (cmd_ready) begin
                cmd_valid = 1'b1;
                cmd_data  = b;
                @(negedge clk);
                cmd_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (exp_rsp.size() == 0 && exp_sh.size() == 0 && cmd_ready && !sclk) break;
        end
        check(exp_rsp.size() == 0, "R4/R8 responses", exp_rsp.size(), 0);
        check(exp_sh.size() == 0, "R7 shifted bytes", exp_sh.size(), 0);
    endtask

    // Response monitor.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rsp.size() == 0) begin
                check(1'b0, "R4/R8 unexpected response", rsp_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_rsp.pop_front();
                check(rsp_data == e, "R4/R8 response byte", rsp_data, e);
            end
        end
    end

    // Serial monitor: assembles bytes at sclk rises and checks period.
    int cyc = 0;
    int last_rise = 0;
    int bit_idx = 0;
    logic sclk_prev = 1'b0;
    logic [7:0] asm_byte = '0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sclk && !sclk_prev) begin
            asm_byte[bit_idx] = sdo;
            if (bit_idx > 0)
                check(cyc - last_rise == 2 * exp_half, "R5 sclk period", cyc - last_rise, 2 * exp_half);
            last_rise = cyc;
            if (bit_idx == 7) begin
                bit_idx = 0;
                if (exp_sh.size() == 0) begin
                    check(1'b0, "R7 unexpected shifted byte", asm_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_sh.pop_front();
                    check(asm_byte == e, "R7 shifted byte", asm_byte, e);
                end
            end else begin
                bit_idx++;
            end
        end
        sclk_prev = sclk;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(lo_pin == 0 && lo_oe == 0, "R1 low bank", {lo_pin, lo_oe}, 0);
        check(hi_pin == 0 && hi_oe == 0, "R1 high bank", {hi_pin, hi_oe}, 0);
        check(!sclk && !rsp_valid && cmd_ready, "R1 idle outputs", {sclk, rsp_valid, cmd_ready}, 3'b001);

        // R2 low bank, masked pins output 0
        send(8'h10); send(8'hA5); send(8'h0F);
        check(lo_pin == 8'h05, "R2 lo_pin", lo_pin, 8'h05);
        check(lo_oe == 8'h0F, "R2 lo_oe", lo_oe, 8'h0F);
        send(8'h10); send(8'hFF); send(8'hF0);
        check(lo_pin == 8'hF0 && lo_oe == 8'hF0, "R2 second write", {lo_pin, lo_oe}, 16'hF0F0);

        // R3 high bank, low bank unchanged
        send(8'h11); send(8'h3C); send(8'hFF);
        check(hi_pin == 8'h3C && hi_oe == 8'hFF, "R3 high bank", {hi_pin, hi_oe}, 16'h3CFF);
        check(lo_pin == 8'hF0, "R3 low bank kept", lo_pin, 8'hF0);

        // R4 read high bank input
        hi_in = 8'h5A; exp_rsp.push_back(8'h5A); send(8'h12);
        hi_in = 8'hC3; exp_rsp.push_back(8'hC3); send(8'h12);
        drain();

        // R7 two-byte block at reset clock (R5: half = 5), R9 input closed
        exp_half = 5;
        exp_sh.push_back(8'h96); exp_sh.push_back(8'h3D);
        send(8'h30); send(8'h01); send(8'h00);
        send(8'h96);
        repeat (3) @(negedge clk);
        check(!cmd_ready, "R9 ready low while shifting", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_data = 8'h10;
        repeat (12) @(negedge clk);
        check(lo_pin == 8'hF0 && lo_oe == 8'hF0, "R9 held byte ignored", {lo_pin, lo_oe}, 16'hF0F0);
        check(!cmd_ready, "R9 ready still low", cmd_ready, 0);
        cmd_valid = 1'b0;
        send(8'h3D);
        drain();

        // R5/R6 divisor 2, prescaler off: half = 3
        send(8'h20); send(8'h02); send(8'h00); send(8'h21);
        exp_half = 3;
        exp_sh.push_back(8'h81);
        send(8'h30); send(8'h00); send(8'h00); send(8'h81);
        drain();

        // R5/R6 divisor 1, prescaler on: half = 10
        send(8'h20); send(8'h01); send(8'h00); send(8'h22);
        exp_half = 10;
        exp_sh.push_back(8'h4E);
        send(8'h30); send(8'h00); send(8'h00); send(8'h4E);
        drain();

        // R8 unknown opcodes then resume
        exp_rsp.push_back(8'hFA); exp_rsp.push_back(8'h77); send(8'h77);
        exp_rsp.push_back(8'hFA); exp_rsp.push_back(8'h00); send(8'h00);
        send(8'h10); send(8'h12); send(8'hFF);
        check(lo_pin == 8'h12 && lo_oe == 8'hFF, "R8 decoding resumes", {lo_pin, lo_oe}, 16'h12FF);
        drain();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule